// File: doc/BRIEF.md
# Dual-Redundant Controller Fault Supervisor

Two identical copies of this block sit in two redundant controller instances. Both instances drive the same PWM line of a switching converter. Each copy reports whether its own instance is online and watches an offline flag that comes from its peer. If the peer's flag stays high without a break for a set number of cycles, the peer is taken to have suffered a functional interrupt. The supervisor then asks for the peer to be reconfigured and keeps the control loop running on its own.

When its own instance is the one that failed, the supervisor turns off its output enable so that the shared PWM line is released. It then waits for a reconfiguration request from the peer. It lets the reconfiguration period run out on a timer, which stands in for the bitstream reload, and clears its duty state. Last, it takes the live duty value from the working peer over a parallel bus with a valid strobe, and only then goes back online. The working instance is never reset. An error-injection input drives the local instance into the failed state so that detection and recovery can be exercised.

The block holds the duty state as a saturating up/down counter, stepped by the loop's deadzone comparator. It also contains a simple PWM generator whose free-running period counter is compared with that duty value.

Top module: `redund_supervisor`

## Requirements
- R1: After reset the instance is online: `selfOffline`=0, `pwmEn`=1, `reconfigReqOut`=0, `dutyOut`=0, `dutyOutValid`=1.
- R2: `injectErr` sampled high while online moves the instance offline on that edge (`selfOffline`=1, `pwmEn`=0). The instance stays offline for as long as no reconfiguration request arrives, and `injectErr` has no effect once the instance is offline.
- R3: `reconfigReqOut` rises after `peerOffline` has been sampled high on PEER_TIMEOUT consecutive rising edges while the instance is online. It stays high while `peerOffline` stays high. Any edge that samples `peerOffline` low restarts the count, and `reconfigReqOut` is low whenever `peerOffline` is low.
- R4: While the instance is itself offline, `reconfigReqOut` stays 0 whatever `peerOffline` does.
- R5: `reconfigReqIn` is ignored while online. While offline it starts a reconfiguration phase that lasts RECFG_CYCLES cycles. During that phase `pwmEn`=0 and `selfOffline`=1, and `dutyInValid` is ignored, so `dutyOut` keeps its value.
- R6: The edge that ends the reconfiguration phase clears the duty state to 0 and enters synchronisation, with the instance still offline. In synchronisation, the first edge that samples `dutyInValid`=1 loads `dutyIn` into the duty state and makes the instance online, so `pwmEn`=1.
- R7: While online, the duty state steps on each edge as follows. `stepUp`=1 with `stepDown`=0 adds 1, saturating at 2^DUTY_W-1. `stepDown`=1 with `stepUp`=0 subtracts 1, saturating at 0. Both high or both low leaves it unchanged. Steps are ignored while offline.
- R8: `dutyOut` always shows the duty state, and `dutyOutValid` is 1 exactly while the instance is online.
- R9: `pwmOut` is high in exactly `dutyOut` cycles of every 2^DUTY_W-cycle period (0 gives a line that stays low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| injectErr | input | 1 | Forces a local functional fault |
| stepUp | input | 1 | Comparator says raise duty |
| stepDown | input | 1 | Comparator says lower duty |
| peerOffline | input | 1 | Offline flag from the peer instance |
| reconfigReqIn | input | 1 | Peer asks this instance to reconfigure |
| dutyIn | input | DUTY_W | Duty state offered by the peer |
| dutyInValid | input | 1 | Peer's duty bus is valid |
| selfOffline | output | 1 | This instance is not online |
| reconfigReqOut | output | 1 | Request to reconfigure the peer |
| pwmEn | output | 1 | Output enable for the shared PWM line |
| pwmOut | output | 1 | Raw PWM waveform |
| dutyOut | output | DUTY_W | Current duty state, offered to the peer |
| dutyOutValid | output | 1 | Duty bus valid (instance online) |

## Verification
The bench builds the block with DUTY_W=4, PEER_TIMEOUT=6 and RECFG_CYCLES=4. With a 4-bit duty, both saturation limits and a whole PWM period of 16 cycles can be reached in a few cycles. The short timeout lets the bench probe the exact edge on which the peer request rises, and also check that one low sample restarts the count. The short reconfiguration phase lets the bench watch the enable, the duty value that must not change and the clear at the phase's last edge before synchronisation begins.

// File: rtl/redund_supervisor_pkg.sv
package redund_supervisor_pkg;

  typedef enum logic [1:0] {
    ST_ONLINE  = 2'd0,
    ST_OFFLINE = 2'd1,
    ST_RECFG   = 2'd2,
    ST_SYNC    = 2'd3
  } supState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic stepEn;   // duty counter may step
    logic dutyClr;  // clear duty at end of reconfiguration
    logic dutyLoad; // capture peer duty
    logic tmrRun;   // reconfiguration timer runs
    logic watchEn;  // peer watchdog active
  } supCtrl_t;

endpackage

// File: rtl/redund_supervisor_ctrl.sv
module redund_supervisor_ctrl
  import redund_supervisor_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      injectErr,
  input  logic      reconfigReqIn,
  input  logic      dutyInValid,
  input  logic      reconfDone,
  output supState_e state,
  output supCtrl_t  ctrl
);

  supState_e stateNxt;

  always_comb begin
    stateNxt = state;
    unique case (state)
      ST_ONLINE:  if (injectErr)     stateNxt = ST_OFFLINE;
      ST_OFFLINE: if (reconfigReqIn) stateNxt = ST_RECFG;
      ST_RECFG:   if (reconfDone)    stateNxt = ST_SYNC;
      ST_SYNC:    if (dutyInValid)   stateNxt = ST_ONLINE;
      default:                       stateNxt = ST_OFFLINE;
    endcase
  end

  always_comb begin
    ctrl          = '0;
    ctrl.stepEn   = (state == ST_ONLINE);
    ctrl.watchEn  = (state == ST_ONLINE);
    ctrl.tmrRun   = (state == ST_RECFG);
    ctrl.dutyClr  = (state == ST_RECFG) && reconfDone;
    ctrl.dutyLoad = (state == ST_SYNC) && dutyInValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ONLINE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/redund_supervisor_dp.sv
module redund_supervisor_dp
  import redund_supervisor_pkg::*;
#(
  parameter int DUTY_W       = 8,
  parameter int PEER_TIMEOUT = 1000,
  parameter int RECFG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  supCtrl_t          ctrl,
  input  logic              stepUp,
  input  logic              stepDown,
  input  logic              peerOffline,
  input  logic [DUTY_W-1:0] dutyIn,
  output logic [DUTY_W-1:0] duty,
  output logic              reconfDone,
  output logic              peerExpired,
  output logic              pwmOut
);

  localparam int PCW = $clog2(PEER_TIMEOUT + 1);
  localparam int TW  = $clog2(RECFG_CYCLES + 1);
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  logic [PCW-1:0]    peerCnt;
  logic [TW-1:0]     recfgTmr;
  logic [DUTY_W-1:0] periodCnt;

  assign peerExpired = (peerCnt == PCW'(PEER_TIMEOUT));
  assign reconfDone  = (recfgTmr == TW'(RECFG_CYCLES - 1));
  assign pwmOut      = (periodCnt < duty);

  // Peer watchdog: continuous offline only
  always_ff @(posedge clk) begin
    if (!rstN)                           peerCnt <= '0;
    else if (ctrl.watchEn && peerOffline) begin
      if (!peerExpired)                  peerCnt <= peerCnt + 1'b1;
    end else                             peerCnt <= '0;
  end

  // Reconfiguration emulation timer
  always_ff @(posedge clk) begin
    if (!rstN || !ctrl.tmrRun) recfgTmr <= '0;
    else                       recfgTmr <= recfgTmr + 1'b1;
  end

  // Duty state: saturating up/down counter with clear and load
  always_ff @(posedge clk) begin
    if (!rstN)              duty <= '0;
    else if (ctrl.dutyClr)  duty <= '0;
    else if (ctrl.dutyLoad) duty <= dutyIn;
    else if (ctrl.stepEn) begin
      if (stepUp && !stepDown && duty != DUTY_MAX)   duty <= duty + 1'b1;
      else if (stepDown && !stepUp && duty != '0)    duty <= duty - 1'b1;
    end
  end

  // PWM period counter
  always_ff @(posedge clk) begin
    if (!rstN) periodCnt <= '0;
    else       periodCnt <= periodCnt + 1'b1;
  end

endmodule

// File: rtl/redund_supervisor.sv
module redund_supervisor
  import redund_supervisor_pkg::*;
#(
  parameter int DUTY_W       = 8,
  parameter int PEER_TIMEOUT = 1000,
  parameter int RECFG_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              injectErr,
  input  logic              stepUp,
  input  logic              stepDown,
  input  logic              peerOffline,
  input  logic              reconfigReqIn,
  input  logic [DUTY_W-1:0] dutyIn,
  input  logic              dutyInValid,
  output logic              selfOffline,
  output logic              reconfigReqOut,
  output logic              pwmEn,
  output logic              pwmOut,
  output logic [DUTY_W-1:0] dutyOut,
  output logic              dutyOutValid
);

  supState_e state;
  supCtrl_t  ctrl;
  logic      reconfDone;
  logic      peerExpired;

  redund_supervisor_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .injectErr    (injectErr),
    .reconfigReqIn(reconfigReqIn),
    .dutyInValid  (dutyInValid),
    .reconfDone   (reconfDone),
    .state        (state),
    .ctrl         (ctrl)
  );

  redund_supervisor_dp #(
    .DUTY_W      (DUTY_W),
    .PEER_TIMEOUT(PEER_TIMEOUT),
    .RECFG_CYCLES(RECFG_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .stepUp     (stepUp),
    .stepDown   (stepDown),
    .peerOffline(peerOffline),
    .dutyIn     (dutyIn),
    .duty       (dutyOut),
    .reconfDone (reconfDone),
    .peerExpired(peerExpired),
    .pwmOut     (pwmOut)
  );

  assign selfOffline    = (state != ST_ONLINE);
  assign pwmEn          = (state == ST_ONLINE);
  assign dutyOutValid   = (state == ST_ONLINE);
  assign reconfigReqOut = ctrl.watchEn && peerExpired && peerOffline;

endmodule

// File: rtl/redund_supervisor_chk.sv
module redund_supervisor_chk #(
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              injectErr,
  input logic              stepUp,
  input logic              stepDown,
  input logic              peerOffline,
  input logic [DUTY_W-1:0] dutyIn,
  input logic              dutyInValid,
  input logic              selfOffline,
  input logic              reconfigReqOut,
  input logic              pwmEn,
  input logic [DUTY_W-1:0] dutyOut
);

  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  // R2
  inject_takes_offline_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selfOffline && injectErr) |=> (selfOffline && !pwmEn));

  // R4
  no_req_while_offline_chk: assert property (@(posedge clk) disable iff (!rstN)
    selfOffline |-> !reconfigReqOut);

  // R3
  req_needs_peer_offline_chk: assert property (@(posedge clk) disable iff (!rstN)
    reconfigReqOut |-> (peerOffline && $past(peerOffline)));

  // R6
  rejoin_loads_peer_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwmEn) |-> ($past(dutyInValid) && dutyOut == $past(dutyIn)));

  // R7
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!selfOffline && stepUp && !stepDown && dutyOut != DUTY_MAX)
      |=> (dutyOut == $past(dutyOut) + 1'b1));

endmodule

bind redund_supervisor redund_supervisor_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .injectErr     (injectErr),
  .stepUp        (stepUp),
  .stepDown      (stepDown),
  .peerOffline   (peerOffline),
  .dutyIn        (dutyIn),
  .dutyInValid   (dutyInValid),
  .selfOffline   (selfOffline),
  .reconfigReqOut(reconfigReqOut),
  .pwmEn         (pwmEn),
  .dutyOut       (dutyOut)
);

// File: tb/redund_supervisor_test.sv
`timescale 1ns/1ps
module redund_supervisor_test;

  localparam int DW  = 4;
  localparam int TMO = 6;
  localparam int RCY = 4;

  logic clk = 0;
  logic rstN = 0;
  logic injectErr = 0, stepUp = 0, stepDown = 0, peerOffline = 0;
  logic reconfigReqIn = 0, dutyInValid = 0;
  logic [DW-1:0] dutyIn = '0;
  logic selfOffline, reconfigReqOut, pwmEn, pwmOut, dutyOutValid;
  logic [DW-1:0] dutyOut;

  int checks = 0;
  int errs = 0;

  always #5 clk = ~clk;

  redund_supervisor #(.DUTY_W(DW), .PEER_TIMEOUT(TMO), .RECFG_CYCLES(RCY)) uut (
    .clk(clk), .rstN(rstN), .injectErr(injectErr), .stepUp(stepUp),
    .stepDown(stepDown), .peerOffline(peerOffline), .reconfigReqIn(reconfigReqIn),
    .dutyIn(dutyIn), .dutyInValid(dutyInValid), .selfOffline(selfOffline),
    .reconfigReqOut(reconfigReqOut), .pwmEn(pwmEn), .pwmOut(pwmOut),
    .dutyOut(dutyOut), .dutyOutValid(dutyOutValid)
  );

  // {stepUp, stepDown, expected duty after the edge}
  localparam logic [5:0] VEC [0:7] = '{
    {2'b01, 4'd0}, {2'b10, 4'd1}, {2'b10, 4'd2}, {2'b11, 4'd2},
    {2'b00, 4'd2}, {2'b01, 4'd1}, {2'b10, 4'd2}, {2'b10, 4'd3}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  endtask

  task automatic pwm_count(input int expHigh, input string req);
    int hi = 0;
    for (int i = 0; i < (1 << DW); i++) begin
      if (pwmOut) hi++;
      tick();
    end
    chk(req, hi, expHigh);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 selfOffline", selfOffline, 0);
    chk("R1 pwmEn", pwmEn, 1);
    chk("R1 reconfigReqOut", reconfigReqOut, 0);
    chk("R1 dutyOut", dutyOut, 0);
    chk("R8 dutyOutValid online", dutyOutValid, 1);

    // R9 zero duty
    pwm_count(0, "R9 duty 0");

    // R7 vector walk
    for (int i = 0; i < 8; i++) begin
      {stepUp, stepDown} = VEC[i][5:4];
      tick();
      chk("R7 step vector", dutyOut, VEC[i][3:0]);
    end
    // R7 upper saturation
    stepUp = 1; stepDown = 0;
    repeat (20) tick();
    chk("R7 saturate high", dutyOut, 15);
    stepUp = 0; stepDown = 1;
    repeat (10) tick();
    stepDown = 0;
    chk("R8 dutyOut after steps", dutyOut, 5);
    pwm_count(5, "R9 duty 5");

    // R3 peer watchdog
    peerOffline = 1;
    repeat (TMO - 1) tick();
    chk("R3 before timeout", reconfigReqOut, 0);
    tick();
    chk("R3 at timeout", reconfigReqOut, 1);
    tick();
    chk("R3 held", reconfigReqOut, 1);
    peerOffline = 0;
    #1 chk("R3 low with peer online", reconfigReqOut, 0);
    tick();
    peerOffline = 1;
    repeat (TMO - 1) tick();
    chk("R3 count restarted", reconfigReqOut, 0);
    tick();
    chk("R3 second timeout", reconfigReqOut, 1);
    peerOffline = 0;
    tick();

    // R5 request ignored while online
    reconfigReqIn = 1; tick(); reconfigReqIn = 0;
    chk("R5 req ignored online", selfOffline, 0);
    chk("R5 pwmEn kept", pwmEn, 1);

    // R2 injection
    injectErr = 1; tick(); injectErr = 0;
    chk("R2 offline after inject", selfOffline, 1);
    chk("R2 pwmEn off", pwmEn, 0);
    chk("R8 dutyOutValid offline", dutyOutValid, 0);
    stepUp = 1; tick(); stepUp = 0;
    chk("R7 step ignored offline", dutyOut, 5);
    // R4 no request while offline
    peerOffline = 1;
    repeat (TMO + 4) tick();
    chk("R4 no request while offline", reconfigReqOut, 0);
    peerOffline = 0;
    injectErr = 1;
    repeat (10) tick();
    injectErr = 0;
    chk("R2 stays offline", selfOffline, 1);

    // R5 / R6 reconfiguration and resync
    reconfigReqIn = 1; tick(); reconfigReqIn = 0;
    dutyIn = 4'd9; dutyInValid = 1;
    tick();
    chk("R5 pwmEn off in reconfig", pwmEn, 0);
    chk("R5 dutyInValid ignored in reconfig", dutyOut, 5);
    repeat (RCY - 2) tick();
    chk("R5 still reconfig", dutyOut, 5);
    dutyInValid = 0;
    tick();
    chk("R6 duty cleared", dutyOut, 0);
    chk("R6 offline in sync", selfOffline, 1);
    tick();
    chk("R6 waits for valid", selfOffline, 1);
    dutyInValid = 1;
    tick();
    dutyInValid = 0;
    chk("R6 duty loaded", dutyOut, 9);
    chk("R6 online again", selfOffline, 0);
    chk("R6 pwmEn on", pwmEn, 1);
    pwm_count(9, "R9 duty 9");

    summary();
  end

endmodule